// File: doc/BRIEF.md
# Clause 22 Management Interface Master with Port Gating

This block runs Clause 22 management frames on a two-wire management bus (a clock MDC and a bidirectional data line) on behalf of a simple register-write interface. Software sets up a target through three registers: a target register holding the PHY port and the register number, a command register holding the 16-bit data, the operation, a single-address flag, a clock-range field, a busy flag and a sticky error flag, and a gate register that marks which of the low ports are Clause 22 devices.

A transfer starts when the command register is written with its busy bit set. The block first checks the request. It accepts the request only if the port number is below the number of gated ports, that port's gate bit is set, and the operation code is valid. A rejected request never reaches the bus and sets the sticky error flag. An accepted request clocks out a complete Clause 22 frame at a rate chosen by the clock-range field. A read releases the data line at the turnaround and collects the PHY's 16 reply bits. The busy bit clears when the frame is over, and a read's result is then in the low half of the command register.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset, all three registers (select 0 = target, 1 = command, 2 = gate) read as 0, MDC is low and the data line is not driven (mdio_oe_o = 0).
- R2: An accepted write (operation field bits 17:16 = 1) clocks out 64 bits, most significant first, one per MDC rising edge: 32 ones, start 01, opcode 01, 5-bit port, 5-bit register, turnaround 10, then the 16 data bits. The block drives the line for the whole frame.
- R3: An accepted read (operation field = 3) sends opcode 10 and releases the line from the first turnaround bit to the end of the frame. It samples 16 reply bits on MDC rising edges, most significant first, and places them in command bits 15:0 by the time busy reads 0.
- R4: A launch whose port (target bits 20:16) is 4 or higher produces no MDC edge, leaves busy at 0 and sets the error flag (command bit 23).
- R5: A launch to a port whose gate bit (gate bit n for port n, bits 3:0) is clear, or one with operation code 0 or 2, is rejected in the same way as R4.
- R6: The error flag stays set until the command register is written while idle with bit 23 = 1; writes without that bit, and writes to other registers, leave it set.
- R7: While no frame is running, MDC stays low and the data line is not driven.
- R8: While busy, writes to every register are ignored: target, gate and command contents are unchanged when the frame ends.
- R9: The MDC half period is 2^(cr+1) system clocks, where cr is command bits 21:19. The driven data bit changes only while MDC is low.
- R10: The target register reads back the port in bits 20:16 and the register number in bits 4:0, with all other bits 0. The command register reads back data, operation, the single-address flag (bit 18) and cr, with busy at bit 22. Bit 22 reads 1 from the cycle after an accepted launch until the frame ends. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 target, 1 command, 2 gate |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe_o | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value as seen at the pad |

## Verification
The bound checker enforces, on every cycle, the bus rules that hold in any state. MDC stays low and the line is undriven when idle. A write frame drives the line throughout, and a read frame stays released after its turnaround. Rejected launches never raise busy. The error flag stays set until it is cleared. The target register holds still while a frame runs. Only the bench scenarios can show the frame contents: the exact bit order of write and read frames, the reply data landing in the command register, the MDC half period for a given clock range, and the gate and opcode combinations that cause a rejection. The bench checks these against a simple PHY model on the bus.

// File: rtl/mdio_c22_pkg.sv
package mdio_c22_pkg;

   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      SEL_TARGET = 2'd0,
      SEL_CMD    = 2'd1,
      SEL_GATE   = 2'd2
   } reg_sel_e;

   // command register field positions
   localparam int CMD_DATA_LSB  = 0;
   localparam int CMD_OP_LSB    = 16;
   localparam int CMD_SADDR_BIT = 18;
   localparam int CMD_CR_LSB    = 19;
   localparam int CMD_BUSY_BIT  = 22;
   localparam int CMD_ERR_BIT   = 23;

   // target register field positions
   localparam int TGT_PORT_LSB  = 16;
   localparam int TGT_REG_LSB   = 0;

   localparam logic [1:0] OP_CODE_WR = 2'b01;
   localparam logic [1:0] OP_CODE_RD = 2'b11;

   // on-wire fields
   localparam logic [1:0] WIRE_START = 2'b01;
   localparam logic [1:0] WIRE_OP_WR = 2'b01;
   localparam logic [1:0] WIRE_OP_RD = 2'b10;
   localparam logic [1:0] WIRE_TA_WR = 2'b10;

endpackage

// File: rtl/mdio_c22_regs.sv
module mdio_c22_regs
   import mdio_c22_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int CR_W      = 3,
   parameter int DATA_W    = 16,
   parameter int PHY_W     = 5,
   parameter int REGA_W    = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [1:0]        sel_i,
   input  logic [REG_W-1:0]  wdata_i,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [REG_W-1:0]  rdata_o,
   output logic              launch_o,
   output logic              is_rd_o,
   output logic [PHY_W-1:0]  port_o,
   output logic [REGA_W-1:0] regad_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [CR_W-1:0]   cr_o,
   output logic              err_o
);

   logic [PHY_W-1:0]     port_q;
   logic [REGA_W-1:0]    regad_q;
   logic [NUM_PORTS-1:0] gate_q;
   logic [DATA_W-1:0]    data_q;
   logic [1:0]           op_q;
   logic                 saddr_q;
   logic [CR_W-1:0]      cr_q;
   logic                 err_q;

   logic wr_tgt, wr_cmd, wr_gate, go, op_ok, port_ok, reject;
   logic [1:0] new_op;
   logic [NUM_PORTS-1:0] hit;

   assign wr_tgt  = wr_i && (sel_i == SEL_TARGET) && !busy_i;
   assign wr_cmd  = wr_i && (sel_i == SEL_CMD)    && !busy_i;
   assign wr_gate = wr_i && (sel_i == SEL_GATE)   && !busy_i;

   assign go     = wr_cmd && wdata_i[CMD_BUSY_BIT];
   assign new_op = wdata_i[CMD_OP_LSB +: 2];
   assign op_ok  = (new_op == OP_CODE_WR) || (new_op == OP_CODE_RD);

   // one comparator per gated port
   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      assign hit[i] = gate_q[i] && (port_q == PHY_W'(i));
   end
   assign port_ok = |hit;

   assign launch_o  = go && op_ok && port_ok;
   assign reject    = go && !launch_o;
   assign is_rd_o   = (new_op == OP_CODE_RD);
   assign port_o    = port_q;
   assign regad_o   = regad_q;
   assign wr_data_o = wdata_i[CMD_DATA_LSB +: DATA_W];
   assign cr_o      = cr_q;
   assign err_o     = err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         port_q  <= '0;
         regad_q <= '0;
      end else if (wr_tgt) begin
         port_q  <= wdata_i[TGT_PORT_LSB +: PHY_W];
         regad_q <= wdata_i[TGT_REG_LSB +: REGA_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      gate_q <= '0;
      else if (wr_gate) gate_q <= wdata_i[NUM_PORTS-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q  <= '0;
         op_q    <= '0;
         saddr_q <= 1'b0;
         cr_q    <= '0;
      end else if (wr_cmd) begin
         data_q  <= wdata_i[CMD_DATA_LSB +: DATA_W];
         op_q    <= new_op;
         saddr_q <= wdata_i[CMD_SADDR_BIT];
         cr_q    <= wdata_i[CMD_CR_LSB +: CR_W];
      end else if (done_i && (op_q == OP_CODE_RD)) begin
         data_q  <= rd_data_i;
      end
   end

   // sticky error: set by a rejected launch, cleared by write-one
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  err_q <= 1'b0;
      else if (reject)                              err_q <= 1'b1;
      else if (wr_cmd && wdata_i[CMD_ERR_BIT])      err_q <= 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel_i)
         SEL_TARGET: begin
            rdata_o[TGT_PORT_LSB +: PHY_W] = port_q;
            rdata_o[TGT_REG_LSB +: REGA_W] = regad_q;
         end
         SEL_CMD: begin
            rdata_o[CMD_DATA_LSB +: DATA_W] = data_q;
            rdata_o[CMD_OP_LSB +: 2]        = op_q;
            rdata_o[CMD_SADDR_BIT]          = saddr_q;
            rdata_o[CMD_CR_LSB +: CR_W]     = cr_q;
            rdata_o[CMD_BUSY_BIT]           = busy_i;
            rdata_o[CMD_ERR_BIT]            = err_q;
         end
         SEL_GATE: rdata_o[NUM_PORTS-1:0] = gate_q;
         default:  rdata_o = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{wdata_i[REG_W-1:CMD_ERR_BIT+1]};

endmodule

// File: rtl/mdio_c22_mdc_div.sv
module mdio_c22_mdc_div #(
   parameter int CR_W = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            run_i,
   input  logic [CR_W-1:0] cr_i,
   output logic            tick_o
);

   localparam int DIV_W = (1 << CR_W) + 1;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] half_m1;

   // half period = 2^(cr+1) system clocks
   assign half_m1 = (DIV_W'(1) << (int'(cr_i) + 1)) - DIV_W'(1);
   assign tick_o  = run_i && (cnt_q == half_m1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (!run_i || tick_o)  cnt_q <= '0;
      else                        cnt_q <= cnt_q + DIV_W'(1);
   end

endmodule

// File: rtl/mdio_c22_frame.sv
module mdio_c22_frame
   import mdio_c22_pkg::*;
#(
   parameter int PRE_BITS = 32,
   parameter int PHY_W    = 5,
   parameter int REGA_W   = 5,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              launch_i,
   input  logic              is_rd_i,
   input  logic [PHY_W-1:0]  port_i,
   input  logic [REGA_W-1:0] regad_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              tick_i,
   input  logic              mdi_i,
   output logic              active_o,
   output logic              mdc_o,
   output logic              mdo_o,
   output logic              oe_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [CNT_W-1:0]  bit_idx_o
);

   localparam int HDR_BITS   = PRE_BITS + 4 + PHY_W + REGA_W;
   localparam int TA_POS     = HDR_BITS;
   localparam int DATA_POS   = HDR_BITS + 2;
   localparam int FRAME_BITS = DATA_POS + DATA_W;

   logic [FRAME_BITS-1:0] sh_q;
   logic [FRAME_BITS-1:0] frame;
   logic [CNT_W-1:0]      cnt_q;
   logic                  hi_q;
   logic                  act_q;
   logic                  rd_q;
   logic [DATA_W-1:0]     rsh_q;
   logic                  last_bit;

   assign frame = {{PRE_BITS{1'b1}}, WIRE_START,
                   is_rd_i ? WIRE_OP_RD : WIRE_OP_WR,
                   port_i, regad_i,
                   is_rd_i ? 2'b11 : WIRE_TA_WR,
                   is_rd_i ? {DATA_W{1'b1}} : wr_data_i};

   assign last_bit = (cnt_q == CNT_W'(FRAME_BITS - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         hi_q  <= 1'b0;
         rd_q  <= 1'b0;
         cnt_q <= '0;
         sh_q  <= '0;
         rsh_q <= '0;
      end else if (launch_i) begin
         act_q <= 1'b1;
         hi_q  <= 1'b0;
         rd_q  <= is_rd_i;
         cnt_q <= '0;
         sh_q  <= frame;
      end else if (act_q && tick_i) begin
         if (!hi_q) begin
            // rising MDC: sample reply bits during the data field
            hi_q <= 1'b1;
            if (rd_q && (cnt_q >= CNT_W'(DATA_POS)))
               rsh_q <= {rsh_q[DATA_W-2:0], mdi_i};
         end else begin
            // falling MDC: advance to next bit
            hi_q <= 1'b0;
            if (last_bit) begin
               act_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
               sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
            end
         end
      end
   end

   assign active_o  = act_q;
   assign mdc_o     = hi_q;
   assign mdo_o     = act_q ? sh_q[FRAME_BITS-1] : 1'b1;
   assign oe_o      = act_q && !(rd_q && (cnt_q >= CNT_W'(TA_POS)));
   assign done_o    = act_q && tick_i && hi_q && last_bit;
   assign rd_data_o = rsh_q;
   assign bit_idx_o = cnt_q;

endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
   import mdio_c22_pkg::*;
#(
   parameter int NUM_C22_PORTS = 4,
   parameter int CR_W          = 3,
   parameter int PRE_BITS      = 32,
   parameter int PHY_W         = 5,
   parameter int REGA_W        = 5,
   parameter int DATA_W        = 16
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        reg_wr_i,
   input  logic [1:0]  reg_sel_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   output logic        mdc_o,
   output logic        mdio_o,
   output logic        mdio_oe_o,
   input  logic        mdio_i
);

   localparam int TA_POS     = PRE_BITS + 4 + PHY_W + REGA_W;
   localparam int FRAME_BITS = TA_POS + 2 + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   // elaboration-time parameter checks
   if (NUM_C22_PORTS < 1 || NUM_C22_PORTS > (1 << PHY_W) || NUM_C22_PORTS > REG_W) begin : g_bad_ports
      $error("NUM_C22_PORTS out of range");
   end
   if (CMD_CR_LSB + CR_W != CMD_BUSY_BIT) begin : g_bad_cr
      $error("clock-range field must end just below busy");
   end
   if (DATA_W != CMD_OP_LSB) begin : g_bad_data
      $error("data field must fill the bits below the operation field");
   end
   if (TGT_PORT_LSB + PHY_W > REG_W || REGA_W > TGT_PORT_LSB) begin : g_bad_tgt
      $error("target register fields overlap");
   end
   if (PRE_BITS < 1) begin : g_bad_pre
      $error("preamble must be at least one bit");
   end

   logic              busy;
   logic              done;
   logic              launch;
   logic              is_rd;
   logic              tick;
   logic              err;
   logic [PHY_W-1:0]  port;
   logic [REGA_W-1:0] regad;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic [CR_W-1:0]   cr;
   logic [CNT_W-1:0]  bit_idx;

   mdio_c22_regs #(
      .NUM_PORTS (NUM_C22_PORTS),
      .CR_W      (CR_W),
      .DATA_W    (DATA_W),
      .PHY_W     (PHY_W),
      .REGA_W    (REGA_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_wr_i),
      .sel_i     (reg_sel_i),
      .wdata_i   (reg_wdata_i),
      .busy_i    (busy),
      .done_i    (done),
      .rd_data_i (rd_data),
      .rdata_o   (reg_rdata_o),
      .launch_o  (launch),
      .is_rd_o   (is_rd),
      .port_o    (port),
      .regad_o   (regad),
      .wr_data_o (wr_data),
      .cr_o      (cr),
      .err_o     (err)
   );

   mdio_c22_mdc_div #(
      .CR_W (CR_W)
   ) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (busy),
      .cr_i   (cr),
      .tick_o (tick)
   );

   mdio_c22_frame #(
      .PRE_BITS (PRE_BITS),
      .PHY_W    (PHY_W),
      .REGA_W   (REGA_W),
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W)
   ) u_frame (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .launch_i  (launch),
      .is_rd_i   (is_rd),
      .port_i    (port),
      .regad_i   (regad),
      .wr_data_i (wr_data),
      .tick_i    (tick),
      .mdi_i     (mdio_i),
      .active_o  (busy),
      .mdc_o     (mdc_o),
      .mdo_o     (mdio_o),
      .oe_o      (mdio_oe_o),
      .done_o    (done),
      .rd_data_o (rd_data),
      .bit_idx_o (bit_idx)
   );

endmodule

// File: rtl/mdio_c22_chk.sv
module mdio_c22_chk #(
   parameter int NUM_PORTS = 4,
   parameter int PHY_W     = 5,
   parameter int CNT_W     = 7,
   parameter int TA_POS    = 46
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr,
   input logic [1:0]       sel,
   input logic [31:0]      wdata,
   input logic             mdc,
   input logic             oe,
   input logic             busy,
   input logic             err,
   input logic             rd_frame,
   input logic [PHY_W-1:0] port,
   input logic [CNT_W-1:0] bit_idx
);

   AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !oe)); // R7

   AST_HIGH_PORT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == 2'd1 && wdata[22] && !busy && (int'(port) >= NUM_PORTS))
      |=> (!busy && err)); // R4

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(wr && sel == 2'd1 && !busy && wdata[23])) |=> err); // R6

   AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_frame && (int'(bit_idx) >= TA_POS)) |-> !oe); // R3

   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_frame) |-> oe); // R2

   AST_BUSY_LOCKS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr && sel == 2'd0) |=> $stable(port)); // R8

endmodule

bind mdio_c22_master mdio_c22_chk #(
   .NUM_PORTS (NUM_C22_PORTS),
   .PHY_W     (PHY_W),
   .CNT_W     (CNT_W),
   .TA_POS    (TA_POS)
) u_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .wr       (reg_wr_i),
   .sel      (reg_sel_i),
   .wdata    (reg_wdata_i),
   .mdc      (mdc_o),
   .oe       (mdio_oe_o),
   .busy     (busy),
   .err      (err),
   .rd_frame (u_frame.rd_q),
   .port     (port),
   .bit_idx  (bit_idx)
);

// File: tb/mdio_c22_master_tb.sv
`timescale 1ns/1ps
module mdio_c22_master_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  sel = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        mdc, mdo, oe;
   logic        line;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   // PHY model state
   int          rise_n = 0;
   int          hdr_undriven = 0;
   int          tail_released = 0;
   int          mdo_bad = 0;
   int          hi_cycles = 0;
   realtime     t_rise = 0;
   logic [63:0] cap = '0;
   logic [15:0] phy_reply = '0;
   logic        phy_drv = 1'b1;

   assign line = oe ? mdo : phy_drv;

   mdio_c22_master u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_wr_i    (wr),
      .reg_sel_i   (sel),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .mdc_o       (mdc),
      .mdio_o      (mdo),
      .mdio_oe_o   (oe),
      .mdio_i      (line)
   );

   always @(posedge mdc) begin
      cap = {cap[62:0], line};
      if (rise_n < 46) begin
         if (!oe) hdr_undriven++;
      end else begin
         if (!oe) tail_released++;
      end
      rise_n++;
      t_rise = $realtime;
   end

   always @(negedge mdc) begin
      hi_cycles = int'(($realtime - t_rise) / 10.0);
      if (rise_n == 47)                     phy_drv = 1'b0;
      else if (rise_n >= 48 && rise_n < 64) phy_drv = phy_reply[63 - rise_n];
      else                                  phy_drv = 1'b1;
   end

   always @(mdo) if (mdc) mdo_bad++;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] s, output logic [31:0] v);
      @(negedge clk);
      sel = s;
      #1 v = rdata;
   endtask

   task automatic clear_phy();
      rise_n = 0; hdr_undriven = 0; tail_released = 0; mdo_bad = 0;
      cap = '0; phy_drv = 1'b1;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 40000; i++) begin
         reg_rd(2'd1, v);
         if (!v[22]) break;
      end
   endtask

   function automatic logic [31:0] cmd_word(input logic busy, input logic [2:0] cr,
                                            input logic [1:0] op, input logic [15:0] d);
      return {8'h00, 1'b0, busy, cr, 1'b1, op, d};
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      for (int s = 0; s < 4; s++) begin
         reg_rd(2'(s), v);
         chk("R1 register reset value", {32'h0, v}, 64'h0);
      end
      chk("R1 mdc/oe after reset", {62'h0, mdc, oe}, 64'h0);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      clear_phy();
      reg_wr(2'd0, 32'hFFFF_FFFF);
      reg_rd(2'd0, v);
      chk("R10 target readback", {32'h0, v}, 64'h001F_001F);
      reg_wr(2'd2, 32'hFFFF_FFFF);
      reg_rd(2'd2, v);
      chk("R10 gate readback", {32'h0, v}, 64'hF);
      reg_wr(2'd1, 32'h00BF_1234);
      reg_rd(2'd1, v);
      chk("R10 command readback without launch", {32'h0, v}, 64'h003F_1234);
      repeat (20) @(negedge clk);
      chk("R7 no MDC edge without busy", 64'(rise_n), 64'd0);
   endtask

   task automatic t_write(input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d, input logic [2:0] cr);
      logic [31:0] v;
      clear_phy();
      reg_wr(2'd0, {11'h0, p, 11'h0, r});
      reg_wr(2'd1, cmd_word(1'b1, cr, 2'b01, d));
      reg_rd(2'd1, v);
      chk("R10 busy set after launch", {63'h0, v[22]}, 64'h1);
      wait_idle();
      chk("R2 write frame bits", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d});
      chk("R2 write frame length", 64'(rise_n), 64'd64);
      chk("R2 line driven through write", 64'(hdr_undriven + tail_released), 64'd0);
      chk("R9 data changes only with MDC low", 64'(mdo_bad), 64'd0);
      chk("R9 MDC high time", 64'(hi_cycles), 64'(1 << (cr + 1)));
      reg_rd(2'd1, v);
      chk("R10 command after write", {32'h0, v}, {32'h0, cmd_word(1'b0, cr, 2'b01, d)});
   endtask

   task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] reply);
      logic [31:0] v;
      clear_phy();
      phy_reply = reply;
      reg_wr(2'd0, {11'h0, p, 11'h0, r});
      reg_wr(2'd1, cmd_word(1'b1, 3'd0, 2'b11, 16'h0000));
      wait_idle();
      chk("R3 read frame bits", cap, {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 2'b10, reply});
      chk("R3 header driven", 64'(hdr_undriven), 64'd0);
      chk("R3 released from turnaround", 64'(tail_released), 64'd18);
      reg_rd(2'd1, v);
      chk("R3 reply in data field", {48'h0, v[15:0]}, {48'h0, reply});
   endtask

   task automatic t_high_port();
      logic [31:0] v;
      clear_phy();
      reg_wr(2'd2, 32'hF);
      reg_wr(2'd0, {11'h0, 5'd5, 11'h0, 5'd1});
      reg_wr(2'd1, cmd_word(1'b1, 3'd0, 2'b01, 16'hBEEF));
      repeat (30) @(negedge clk);
      reg_rd(2'd1, v);
      chk("R4 error set, busy clear", {62'h0, v[23], v[22]}, 64'h2);
      chk("R4 no MDC edge", 64'(rise_n), 64'd0);
   endtask

   task automatic t_sticky();
      logic [31:0] v;
      reg_wr(2'd2, 32'h3);
      reg_wr(2'd0, 32'h0001_0002);
      reg_rd(2'd1, v);
      chk("R6 error kept over other writes", {63'h0, v[23]}, 64'h1);
      reg_wr(2'd1, cmd_word(1'b0, 3'd0, 2'b01, 16'h0));
      reg_rd(2'd1, v);
      chk("R6 error kept without clear bit", {63'h0, v[23]}, 64'h1);
      reg_wr(2'd1, 32'h0080_0000);
      reg_rd(2'd1, v);
      chk("R6 error cleared by write-one", {63'h0, v[23]}, 64'h0);
   endtask

   task automatic t_gated();
      logic [31:0] v;
      clear_phy();
      reg_wr(2'd2, 32'h7);
      reg_wr(2'd0, {11'h0, 5'd3, 11'h0, 5'd0});
      reg_wr(2'd1, cmd_word(1'b1, 3'd0, 2'b01, 16'h1));
      repeat (20) @(negedge clk);
      reg_rd(2'd1, v);
      chk("R5 gated-off port rejected", {62'h0, v[23], v[22]}, 64'h2);
      chk("R5 gated-off port no MDC", 64'(rise_n), 64'd0);
      reg_wr(2'd1, 32'h0080_0000);
      reg_wr(2'd0, {11'h0, 5'd0, 11'h0, 5'd0});
      reg_wr(2'd1, cmd_word(1'b1, 3'd0, 2'b10, 16'h1));
      repeat (20) @(negedge clk);
      reg_rd(2'd1, v);
      chk("R5 bad operation code rejected", {62'h0, v[23], v[22]}, 64'h2);
      chk("R5 bad operation code no MDC", 64'(rise_n), 64'd0);
      reg_wr(2'd1, 32'h0080_0000);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      clear_phy();
      reg_wr(2'd2, 32'hF);
      reg_wr(2'd0, {11'h0, 5'd2, 11'h0, 5'd9});
      reg_wr(2'd1, cmd_word(1'b1, 3'd0, 2'b01, 16'h5A5A));
      repeat (10) @(negedge clk);
      reg_wr(2'd0, 32'h0003_0003);
      reg_wr(2'd2, 32'h0);
      reg_wr(2'd1, 32'h00C0_1111);
      wait_idle();
      reg_rd(2'd0, v);
      chk("R8 target unchanged", {32'h0, v}, {32'h0, 11'h0, 5'd2, 11'h0, 5'd9});
      reg_rd(2'd2, v);
      chk("R8 gate unchanged", {32'h0, v}, 64'hF);
      reg_rd(2'd1, v);
      chk("R8 command unchanged", {32'h0, v}, {32'h0, cmd_word(1'b0, 3'd0, 2'b01, 16'h5A5A)});
      chk("R8 frame unchanged", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd9, 2'b10, 16'h5A5A});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_write(5'd1, 5'd5, 16'hA5C3, 3'd0);
      t_write(5'd3, 5'd31, 16'h0F0F, 3'd2);
      t_read(5'd2, 5'd31, 16'h3C5A);
      t_read(5'd0, 5'd4, 16'h8001);
      t_high_port();
      t_sticky();
      t_gated();
      t_busy_ignore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule